// File: doc/BRIEF.md
# Coherent Split-Byte Sample Register Bank

This block is a read-only register bank for four 16-bit measurement channels. A measurement engine presents a new sample set and pulses an update strobe. The bank then exposes each channel as two byte registers on a byte-wide read port with one cycle of latency.

Reading a channel's low byte also copies that channel's high byte into a shadow register kept for that channel alone. A later read of the high byte returns the shadow, not the live value. A host that reads the two halves in turn therefore always gets both bytes from the same conversion, even when fresh samples land between the two reads. A word read is two read strobes on consecutive cycles, first the low address and then the high address.

Top module: `sample_bank_top`

## Requirements
- R1: Reset (active low, asynchronous) clears every live channel value and every shadow register, and forces `rdata_o` to 0x00. After reset, every channel address reads 0x00.
- R2: The channel registers sit at byte addresses 0x10 to 0x17, with two addresses per channel. The low byte is at the even address and the high byte at the next odd address. By address the channels are 0 (green) at 0x10, 1 (red) at 0x12, 2 (blue) at 0x14 and 3 (clear) at 0x16.
- R3: A read strobe on a low-byte address puts bits 7:0 of that channel's live value on `rdata_o` in the following cycle.
- R4: A low-byte read of channel N copies bits 15:8 of that channel's live value into shadow N. Shadows of the other channels do not change.
- R5: A high-byte read returns that channel's shadow, not the live value. It matches the last low byte read of that channel even after later updates.
- R6: A high-byte read with no low-byte read of that channel since reset returns 0x00.
- R7: If an update strobe and a low-byte read occur in the same cycle, the returned low byte and the captured shadow both come from the value held before the update.
- R8: A low-byte read followed in the next cycle by a read of the next (high) address returns the two halves of one 16-bit conversion.
- R9: A read of any address outside 0x10 to 0x17 returns 0x00 and leaves every shadow unchanged.
- R10: `upd_i` loads all four channels from `sample_i` (channel c in bits 16c+15:16c). Without `upd_i`, the live values hold.
- R11: In a cycle that follows a cycle with no read strobe, `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Load a new sample set |
| sample_i | input | 64 | Four 16-bit samples, channel c in bits 16c+15:16c |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address of the read |
| rdata_o | output | 8 | Read data, one cycle after the strobe |

## Verification
The hardest case to reach is an update strobe that lands exactly in the cycle of a low-byte read. A second hard case is a high-byte read that follows updates, so that the live and shadow high bytes differ. The vector table drives the update and the read strobe on the same cycle. It then reads the high byte after the live value has changed. Each sample set encodes the channel number and a seed in every byte, so a byte taken from the wrong conversion or the wrong channel yields a different value. Directed steps then cover reset in the middle of a run and out-of-range reads that fall between two shadow reads.

// File: rtl/sample_bank_pkg.sv
package sample_bank_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
endpackage

// File: rtl/sample_live_regs.sv
module sample_live_regs #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               upd_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]         sample_i,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]    live_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    live_o[c] <= '0;
      else if (upd_i) live_o[c] <= sample_i[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  // R10
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(live_o));
endmodule

// File: rtl/sample_addr_dec.sv
module sample_addr_dec
  import sample_bank_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       hit_o,
  output logic [$clog2(NUM_CH)-1:0]  ch_o,
  output half_e                      half_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam int unsigned SPAN = 2 * NUM_CH;

  logic [ADDR_W-1:0] off;

  always_comb begin
    off    = addr_i - BASE_ADDR;
    hit_o  = rd_en_i && (addr_i >= BASE_ADDR) && (off < ADDR_W'(SPAN));
    ch_o   = CH_W'(off >> 1);
    half_o = half_e'(off[0]);
  end
endmodule

// File: rtl/sample_shadow_bank.sv
module sample_shadow_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned HI_W   = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cap_i,
  input  logic [$clog2(NUM_CH)-1:0]        ch_i,
  input  logic [NUM_CH-1:0][HI_W-1:0]      live_hi_i,
  output logic [NUM_CH-1:0][HI_W-1:0]      shadow_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sh
    logic cap_here;
    assign cap_here = cap_i && (ch_i == c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       shadow_o[c] <= '0;
      else if (cap_here) shadow_o[c] <= live_hi_i[c];
    end

    // R4
    shadow_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cap_i && ch_i == c) |=> $stable(shadow_o[c]));
  end
endmodule

// File: rtl/sample_bank_top.sv
module sample_bank_top
  import sample_bank_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        upd_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]  sample_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [BYTE_W-1:0]           rdata_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam int unsigned HI_W = SAMPLE_W - BYTE_W;

  logic [NUM_CH-1:0][SAMPLE_W-1:0] live_q;
  logic [NUM_CH-1:0][HI_W-1:0]     live_hi;
  logic [NUM_CH-1:0][HI_W-1:0]     shadow_q;
  logic                            hit;
  logic [CH_W-1:0]                 ch;
  half_e                           half;

  sample_live_regs #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_live (
    .clk_i, .rst_ni, .upd_i, .sample_i, .live_o(live_q)
  );

  sample_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .rd_en_i, .addr_i, .hit_o(hit), .ch_o(ch), .half_o(half)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hi
    assign live_hi[c] = live_q[c][SAMPLE_W-1:BYTE_W];
  end

  sample_shadow_bank #(.NUM_CH(NUM_CH), .HI_W(HI_W)) u_shadow (
    .clk_i, .rst_ni,
    .cap_i(hit && half == HALF_LO),
    .ch_i(ch),
    .live_hi_i(live_hi),
    .shadow_o(shadow_q)
  );

  // shadow and live capture share this edge, so both see the pre-update value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (!hit)              rdata_o <= '0;
    else if (half == HALF_LO)   rdata_o <= live_q[ch][BYTE_W-1:0];
    else                        rdata_o <= BYTE_W'(shadow_q[ch]);
  end

  // R9
  out_of_range_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i < BASE_ADDR || addr_i >= BASE_ADDR + ADDR_W'(2*NUM_CH)))
      |=> (rdata_o == '0) && $stable(shadow_q));

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);

  // R3
  low_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && half == HALF_LO) |=> rdata_o == $past(live_q[ch][BYTE_W-1:0]));

  // R5
  high_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && half == HALF_HI) |=> rdata_o == BYTE_W'($past(shadow_q[ch])));

  // R7
  coincident_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && half == HALF_LO && upd_i) |=> shadow_q[$past(ch)] == $past(live_hi[ch]));
endmodule

// File: tb/tb_sample_bank_top.sv
module tb_sample_bank_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 19;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_i = 1'b0;
  logic [63:0] sample_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sample_bank_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {upd, seed[3:0], rd, addr[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'h5, 1'b0, 8'h00, 8'h00},  // R10 R11 load seed 5, idle
    {1'b0, 4'h0, 1'b1, 8'h10, 8'h50},  // R3 R2 ch0 low
    {1'b0, 4'h0, 1'b1, 8'h11, 8'h85},  // R8 ch0 high right after
    {1'b0, 4'h0, 1'b1, 8'h13, 8'h00},  // R6 ch1 high, no low read yet
    {1'b0, 4'h0, 1'b1, 8'h12, 8'h51},  // R3 ch1 low
    {1'b1, 4'hA, 1'b1, 8'h13, 8'h95},  // R5 high read during update
    {1'b0, 4'h0, 1'b1, 8'h13, 8'h95},  // R5 shadow kept after update
    {1'b0, 4'h0, 1'b1, 8'h12, 8'hA1},  // R3 new ch1 low
    {1'b0, 4'h0, 1'b1, 8'h13, 8'h9A},  // R8 coherent new pair
    {1'b0, 4'h0, 1'b1, 8'h16, 8'hA3},  // R2 ch3 low
    {1'b0, 4'h0, 1'b1, 8'h17, 8'hBA},  // R2 ch3 high
    {1'b1, 4'h5, 1'b1, 8'h14, 8'hA2},  // R7 update coincides with low read
    {1'b0, 4'h0, 1'b1, 8'h15, 8'hAA},  // R7 shadow from pre-update value
    {1'b0, 4'h0, 1'b1, 8'h14, 8'h52},  // R3 ch2 low post update
    {1'b0, 4'h0, 1'b1, 8'h15, 8'hA5},  // R8 ch2 high
    {1'b0, 4'h0, 1'b1, 8'h18, 8'h00},  // R9 above range
    {1'b0, 4'h0, 1'b1, 8'h0F, 8'h00},  // R9 below range
    {1'b0, 4'h0, 1'b1, 8'h17, 8'hBA},  // R9 R4 ch3 shadow untouched
    {1'b0, 4'h0, 1'b0, 8'h11, 8'h00}   // R11 no strobe
  };

  function automatic logic [63:0] make_samples(input logic [3:0] seed);
    logic [63:0] s;
    for (int c = 0; c < 4; c++)
      s[c*16 +: 16] = {4'(c + 8), seed, seed, 4'(c)};
    return s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic upd, input logic [3:0] seed, input logic rd,
                      input logic [7:0] addr, output logic [7:0] got);
    upd_i    = upd;
    sample_i = make_samples(seed);
    rd_en_i  = rd;
    addr_i   = addr;
    @(negedge clk_i);
    got = rdata_o;
    upd_i   = 1'b0;
    rd_en_i = 1'b0;
  endtask

  initial begin
    logic [7:0] got;
    repeat (2) @(negedge clk_i);
    check("R1 reset rdata", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 8'h10; a <= 8'h17; a++) begin
      step(1'b0, 4'h0, 1'b1, 8'(a), got);
      check("R1 post-reset read", got, 8'h00);
    end

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:17], VEC[i][16], VEC[i][15:8], got);
      check($sformatf("vector %0d", i), got, VEC[i][7:0]);
    end

    // R1 mid-run reset, then R6 high read returns 0 despite earlier low reads
    step(1'b0, 4'h0, 1'b1, 8'h16, got);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset rdata", rdata_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b0, 4'h0, 1'b1, 8'h17, got);
    check("R6 high after reset", got, 8'h00);
    step(1'b0, 4'h0, 1'b1, 8'h12, got);
    check("R1 live cleared", got, 8'h00);

    // R4 only the read channel's shadow moves
    step(1'b1, 4'h3, 1'b0, 8'h00, got);
    step(1'b0, 4'h0, 1'b1, 8'h10, got);
    check("R4 ch0 low", got, 8'h30);
    step(1'b0, 4'h0, 1'b1, 8'h13, got);
    check("R4 ch1 shadow untouched", got, 8'h00);
    step(1'b0, 4'h0, 1'b1, 8'h11, got);
    check("R4 ch0 shadow", got, 8'h83);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule